// File: doc/BRIEF.md
# Register-Space Access Fault Interrupt Unit

This unit sits beside the slave port of a memory-mapped configuration register space and inspects every bus transfer. Each transfer falls into one of three classes: permitted, address error (the offset is not implemented, or the byte address is not word aligned), or protection error (a non-privileged requester touches a register that only privileged code may use). A permitted transfer to one of the unit's own registers reads or updates it. A faulting transfer changes no register. Instead, it sets the raw status bit of its class and, if no fault is already outstanding, records the offending byte address and the transfer attributes.

Software controls interrupts through a raw status register that it can also set for test, an enabled status register that clears bits, a pair of enable set/clear registers, and an end-of-interrupt register. The unit emits a one-cycle pulse when an enabled source becomes pending. It then stays silent until software writes zero to the end-of-interrupt register. The pulse is ORed with the error interrupt of a neighbouring protection module to form a single combined output. Which offsets in the low window (word offsets below `LOW_WORDS`) exist, and which of them are privileged, comes from two parameter masks. Reads of low-window registers return zero here, because their contents are held elsewhere.

Top module: `cfg_fault_irq_unit`

## Requirements
- R1: An access to an unimplemented offset, or to a byte address with bits [1:0] not zero, sets raw status bit 0. Its read data is zero and a write has no effect.
- R2: A non-privileged access to a privileged register sets raw status bit 1 and does not modify that register. The unit's own registers are privileged, except the fault status register at 0xF8.
- R3: A write to the raw status register (0xE0) sets each bit written as 1. A write to the enabled status register (0xE4) clears each bit written as 1. Bits written as 0 are unchanged in both registers.
- R4: A write of 1 to a bit of the enable set register (0xE8) enables that source, and a write of 1 to a bit of the enable clear register (0xEC) disables it. A read of either register returns the enable mask.
- R5: A read of 0xE4 returns the raw status ANDed with the enable mask. Bit 0 is the address error and bit 1 is the protection error.
- R6: When the unit is armed and (raw AND enable) is nonzero at a clock edge, the unit interrupt is high for exactly the following cycle and the unit disarms. It is armed out of reset.
- R7: Only a privileged write of the value 0 to 0xF0 re-arms the unit. If a source is still pending, a new pulse follows one cycle after the write takes effect. A nonzero write does not re-arm.
- R8: The fault address register (0xF4) and the fault status register (0xF8) capture a fault only while raw status is zero, so later faults leave them unchanged. Fault status layout: bits [1:0] = type (01 address, 10 protection), bit 2 = write, bit 3 = privileged.
- R9: `err_irq` is the OR of the unit interrupt and `ext_err_irq`, with no added delay.
- R10: After reset the raw status, enable mask, fault address and fault status read as zero, and `err_irq` is low while `ext_err_irq` is low.
- R11: A permitted access to an implemented low-window register returns zero and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Requester is privileged |
| bus_addr | input | ADDR_W | Byte offset in the register space |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the transfer cycle |
| ext_err_irq | input | 1 | Error interrupt of the neighbouring protection module |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The hardest state to reach from the ports is a disarmed unit that still has a pending enabled source, where only a correct end-of-interrupt write may produce the next pulse. The stimulus enables a source, raises it with an unmapped access, and lets the first pulse pass. It then raises the same source again and tries a nonzero end-of-interrupt write and a non-privileged zero write, and observes that no pulse appears. Only after that does it issue the valid write, expecting a pulse exactly one cycle later. A table of transfers also keeps one fault outstanding while later faults of the other class arrive, to show that the captured address and attributes stay frozen.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam int NUM_SRC  = 2;
    localparam int SRC_ADDR = 0;
    localparam int SRC_PROT = 1;

    localparam logic [1:0] CODE_ADDR = 2'b01;
    localparam logic [1:0] CODE_PROT = 2'b10;

    // Byte offsets of the unit's own registers (software depends on these)
    localparam int unsigned OFF_RAW    = 'hE0;
    localparam int unsigned OFF_ENSTAT = 'hE4;
    localparam int unsigned OFF_ENSET  = 'hE8;
    localparam int unsigned OFF_ENCLR  = 'hEC;
    localparam int unsigned OFF_EOI    = 'hF0;
    localparam int unsigned OFF_FADDR  = 'hF4;
    localparam int unsigned OFF_FSTAT  = 'hF8;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_RAW,
        REG_ENSTAT,
        REG_ENSET,
        REG_ENCLR,
        REG_EOI,
        REG_FADDR,
        REG_FSTAT
    } own_reg_e;

    typedef struct packed {
        logic     addr_err;
        logic     prot_err;
        logic     ok;
        own_reg_e reg_id;
    } acc_class_t;

    // Packed so that code lands in [1:0], write in 2, privilege in 3
    typedef struct packed {
        logic       priv;
        logic       wr;
        logic [1:0] code;
    } fault_attr_t;

endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
    import cfu_pkg::*;
#(
    parameter int          ADDR_W        = 9,
    parameter int          LOW_WORDS     = 16,
    parameter logic [15:0] LOW_MAP_MASK  = 16'hF3FD,
    parameter logic [15:0] LOW_PRIV_MASK = 16'hF3C0
) (
    input  logic              sel,
    input  logic              priv,
    input  logic [ADDR_W-1:0] addr,
    output acc_class_t        cls
);

    localparam int WORD_W    = ADDR_W - 2;
    localparam int LOW_IDX_W = $clog2(LOW_WORDS);

    logic [WORD_W-1:0]    word;
    logic [LOW_IDX_W-1:0] low_idx;
    logic                 aligned;
    logic                 in_low;
    logic [LOW_WORDS-1:0] map_vec;
    logic [LOW_WORDS-1:0] priv_vec;
    own_reg_e             own_id;
    logic                 mapped;
    logic                 restricted;

    // One map and one privilege bit per low-window word
    for (genvar w = 0; w < LOW_WORDS; w++) begin : g_low
        assign map_vec[w]  = LOW_MAP_MASK[w];
        assign priv_vec[w] = LOW_PRIV_MASK[w] & LOW_MAP_MASK[w];
    end

    assign word    = addr[ADDR_W-1:2];
    assign low_idx = word[LOW_IDX_W-1:0];
    assign aligned = (addr[1:0] == 2'b00);
    assign in_low  = (word < WORD_W'(LOW_WORDS));

    always_comb begin
        case (addr)
            ADDR_W'(OFF_RAW):    own_id = REG_RAW;
            ADDR_W'(OFF_ENSTAT): own_id = REG_ENSTAT;
            ADDR_W'(OFF_ENSET):  own_id = REG_ENSET;
            ADDR_W'(OFF_ENCLR):  own_id = REG_ENCLR;
            ADDR_W'(OFF_EOI):    own_id = REG_EOI;
            ADDR_W'(OFF_FADDR):  own_id = REG_FADDR;
            ADDR_W'(OFF_FSTAT):  own_id = REG_FSTAT;
            default:             own_id = REG_NONE;
        endcase
    end

    always_comb begin
        mapped     = 1'b0;
        restricted = 1'b0;
        if (aligned) begin
            if (own_id != REG_NONE) begin
                mapped     = 1'b1;
                restricted = (own_id != REG_FSTAT);
            end else if (in_low) begin
                mapped     = map_vec[low_idx];
                restricted = priv_vec[low_idx];
            end
        end
    end

    always_comb begin
        cls.addr_err = sel && !mapped;
        cls.prot_err = sel && mapped && restricted && !priv;
        cls.ok       = sel && mapped && !(restricted && !priv);
        cls.reg_id   = cls.ok ? own_id : REG_NONE;
    end

endmodule

// File: rtl/cfu_irq_ctrl.sv
module cfu_irq_ctrl
    import cfu_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_set,
    input  logic [N_SRC-1:0] sw_set,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic [N_SRC-1:0] en_set,
    input  logic [N_SRC-1:0] en_clr,
    input  logic             eoi,
    output logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] en,
    output logic             pulse
);

    typedef struct packed {
        logic [N_SRC-1:0] raw;
        logic [N_SRC-1:0] en;
        logic             armed;
        logic             pulse;
    } irq_state_t;

    irq_state_t       st_d, st_q;
    logic [N_SRC-1:0] raw_next;
    logic             pending;
    logic             fire;

    // Per source: a hardware event outranks a software clear
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign raw_next[i] = hw_set[i] | sw_set[i] | (st_q.raw[i] & ~sw_clr[i]);
    end

    always_comb begin
        st_d     = st_q;
        pending  = |(st_q.raw & st_q.en);
        fire     = st_q.armed && pending;
        st_d.raw = raw_next;
        st_d.en  = (st_q.en | en_set) & ~en_clr;
        st_d.pulse = fire;
        if (fire) begin
            st_d.armed = 1'b0;
        end else if (eoi) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{raw: '0, en: '0, armed: 1'b1, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign raw   = st_q.raw;
    assign en    = st_q.en;
    assign pulse = st_q.pulse;

endmodule

// File: rtl/cfu_fault_capture.sv
module cfu_fault_capture
    import cfu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int N_SRC  = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_err,
    input  logic              prot_err,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              priv,
    input  logic [N_SRC-1:0]  raw,
    output logic [ADDR_W-1:0] fault_addr,
    output fault_attr_t       fault_attr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        fault_attr_t       attr;
    } cap_state_t;

    cap_state_t cap_d, cap_q;
    logic       capture;

    always_comb begin
        cap_d   = cap_q;
        capture = (addr_err || prot_err) && (raw == '0);
        if (capture) begin
            cap_d.addr      = addr;
            cap_d.attr.code = addr_err ? CODE_ADDR : CODE_PROT;
            cap_d.attr.wr   = we;
            cap_d.attr.priv = priv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign fault_addr = cap_q.addr;
    assign fault_attr = cap_q.attr;

endmodule

// File: rtl/cfg_fault_irq_unit.sv
module cfg_fault_irq_unit
    import cfu_pkg::*;
#(
    parameter int          ADDR_W        = 9,
    parameter int          DATA_W        = 32,
    parameter int          LOW_WORDS     = 16,
    parameter logic [15:0] LOW_MAP_MASK  = 16'hF3FD,
    parameter logic [15:0] LOW_PRIV_MASK = 16'hF3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_err_irq,
    output logic              err_irq
);

    acc_class_t         cls;
    logic               addr_err_w;
    logic               prot_err_w;
    logic               wr_ok;
    logic               rd_ok;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] hw_set;
    logic [NUM_SRC-1:0] sw_set;
    logic [NUM_SRC-1:0] sw_clr;
    logic [NUM_SRC-1:0] en_set;
    logic [NUM_SRC-1:0] en_clr;
    logic               eoi;
    logic [NUM_SRC-1:0] raw_stat;
    logic [NUM_SRC-1:0] en_mask;
    logic               unit_pulse;
    logic [ADDR_W-1:0]  fault_addr;
    fault_attr_t        fault_attr;

    cfu_decode #(
        .ADDR_W        (ADDR_W),
        .LOW_WORDS     (LOW_WORDS),
        .LOW_MAP_MASK  (LOW_MAP_MASK),
        .LOW_PRIV_MASK (LOW_PRIV_MASK)
    ) u_decode (
        .sel  (bus_sel),
        .priv (bus_priv),
        .addr (bus_addr),
        .cls  (cls)
    );

    assign addr_err_w = cls.addr_err;
    assign prot_err_w = cls.prot_err;
    assign wr_ok      = cls.ok && bus_we;
    assign rd_ok      = cls.ok && !bus_we;
    assign wbits      = bus_wdata[NUM_SRC-1:0];

    always_comb begin
        hw_set           = '0;
        hw_set[SRC_ADDR] = addr_err_w;
        hw_set[SRC_PROT] = prot_err_w;
        sw_set = (wr_ok && cls.reg_id == REG_RAW)    ? wbits : '0;
        sw_clr = (wr_ok && cls.reg_id == REG_ENSTAT) ? wbits : '0;
        en_set = (wr_ok && cls.reg_id == REG_ENSET)  ? wbits : '0;
        en_clr = (wr_ok && cls.reg_id == REG_ENCLR)  ? wbits : '0;
        eoi    = wr_ok && (cls.reg_id == REG_EOI) && (bus_wdata == '0);
    end

    cfu_irq_ctrl #(
        .N_SRC (NUM_SRC)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .en_set (en_set),
        .en_clr (en_clr),
        .eoi    (eoi),
        .raw    (raw_stat),
        .en     (en_mask),
        .pulse  (unit_pulse)
    );

    cfu_fault_capture #(
        .ADDR_W (ADDR_W),
        .N_SRC  (NUM_SRC)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_err   (addr_err_w),
        .prot_err   (prot_err_w),
        .addr       (bus_addr),
        .we         (bus_we),
        .priv       (bus_priv),
        .raw        (raw_stat),
        .fault_addr (fault_addr),
        .fault_attr (fault_attr)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (cls.reg_id)
                REG_RAW:    bus_rdata = DATA_W'(raw_stat);
                REG_ENSTAT: bus_rdata = DATA_W'(raw_stat & en_mask);
                REG_ENSET:  bus_rdata = DATA_W'(en_mask);
                REG_ENCLR:  bus_rdata = DATA_W'(en_mask);
                REG_FADDR:  bus_rdata = DATA_W'(fault_addr);
                REG_FSTAT:  bus_rdata = DATA_W'(fault_attr);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign err_irq = unit_pulse | ext_err_irq;

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int N_SRC  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic              bus_priv,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ext_err_irq,
    input logic              err_irq,
    input logic              addr_err,
    input logic              prot_err,
    input logic [N_SRC-1:0]  raw,
    input logic [N_SRC-1:0]  en,
    input logic              pulse,
    input logic              eoi,
    input logic [ADDR_W-1:0] fault_addr
);

    logic waiting_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (eoi) begin
            waiting_q <= 1'b0;
        end else if (pulse) begin
            waiting_q <= 1'b1;
        end
    end

    a_r1_addr_err_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> raw[0]);

    a_r1_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (bus_rdata == '0));

    a_r2_prot_err_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> raw[1]);

    a_r5_enstat_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_priv && bus_addr == ADDR_W'('hE4))
        |-> (bus_rdata == DATA_W'(raw & en)));

    a_r6_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    a_r7_silent_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        !(waiting_q && pulse));

    a_r8_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (|raw) |=> $stable(fault_addr));

    a_r9_ext_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        ext_err_irq |-> err_irq);

endmodule

bind cfg_fault_irq_unit cfu_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_SRC  (cfu_pkg::NUM_SRC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_priv    (bus_priv),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .ext_err_irq (ext_err_irq),
    .err_irq     (err_irq),
    .addr_err    (addr_err_w),
    .prot_err    (prot_err_w),
    .raw         (raw_stat),
    .en          (en_mask),
    .pulse       (unit_pulse),
    .eoi         (eoi),
    .fault_addr  (fault_addr)
);

// File: tb/tb_cfg_fault_irq_unit.sv
module tb_cfg_fault_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int DW = 32;

    typedef struct packed {
        logic          we;
        logic          priv;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          chk;
        logic [DW-1:0] exp;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h0},  // 0  R10 raw reset
        '{1'b0, 1'b1, 9'h0E8, 32'h0, 1'b1, 32'h0},  // 1  R10 mask reset
        '{1'b1, 1'b1, 9'h0E8, 32'h1, 1'b0, 32'h0},  // 2  R4 enable bit0
        '{1'b0, 1'b1, 9'h0EC, 32'h0, 1'b1, 32'h1},  // 3  R4 mask via clear reg
        '{1'b1, 1'b1, 9'h0E0, 32'h2, 1'b0, 32'h0},  // 4  R3 test set bit1
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h2},  // 5  R3
        '{1'b0, 1'b1, 9'h0E4, 32'h0, 1'b1, 32'h0},  // 6  R5 masked out
        '{1'b1, 1'b1, 9'h0E8, 32'h2, 1'b0, 32'h0},  // 7  R4
        '{1'b0, 1'b1, 9'h0E4, 32'h0, 1'b1, 32'h2},  // 8  R5
        '{1'b1, 1'b1, 9'h0EC, 32'h1, 1'b0, 32'h0},  // 9  R4 disable bit0
        '{1'b0, 1'b1, 9'h0E8, 32'h0, 1'b1, 32'h2},  // 10 R4
        '{1'b1, 1'b1, 9'h0E4, 32'h0, 1'b0, 32'h0},  // 11 R3 zero write
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h2},  // 12 R3 unchanged
        '{1'b1, 1'b1, 9'h0E4, 32'h2, 1'b0, 32'h0},  // 13 R3 clear
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h0},  // 14 R3
        '{1'b0, 1'b0, 9'h00C, 32'h0, 1'b1, 32'h0},  // 15 R11 open word
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h0},  // 16 R11 no error
        '{1'b0, 1'b1, 9'h004, 32'h0, 1'b1, 32'h0},  // 17 R1 hole word
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h1},  // 18 R1
        '{1'b0, 1'b1, 9'h0F4, 32'h0, 1'b1, 32'h4},  // 19 R8 address
        '{1'b0, 1'b0, 9'h0F8, 32'h0, 1'b1, 32'h9},  // 20 R8 attrs, R2 open
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h1},  // 21 R2 no prot raised
        '{1'b1, 1'b0, 9'h0E8, 32'h1, 1'b0, 32'h0},  // 22 R2 rejected write
        '{1'b0, 1'b1, 9'h0E8, 32'h0, 1'b1, 32'h2},  // 23 R2 mask kept
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h3},  // 24 R2
        '{1'b0, 1'b1, 9'h0F8, 32'h0, 1'b1, 32'h9},  // 25 R8 first kept
        '{1'b1, 1'b1, 9'h0E4, 32'h3, 1'b0, 32'h0},  // 26 R3 clear all
        '{1'b1, 1'b0, 9'h00E, 32'h7, 1'b0, 32'h0},  // 27 R1 misaligned
        '{1'b0, 1'b1, 9'h0F4, 32'h0, 1'b1, 32'hE},  // 28 R8
        '{1'b0, 1'b1, 9'h0F8, 32'h0, 1'b1, 32'h5},  // 29 R8
        '{1'b1, 1'b1, 9'h0E4, 32'h1, 1'b0, 32'h0},  // 30 R3
        '{1'b0, 1'b0, 9'h018, 32'h0, 1'b1, 32'h0},  // 31 R2 locked word
        '{1'b0, 1'b1, 9'h0F8, 32'h0, 1'b1, 32'h2},  // 32 R8
        '{1'b0, 1'b1, 9'h0F4, 32'h0, 1'b1, 32'h18}, // 33 R8
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h2},  // 34 R2
        '{1'b1, 1'b1, 9'h0E4, 32'h2, 1'b0, 32'h0},  // 35 R3
        '{1'b1, 1'b1, 9'h0E2, 32'h2, 1'b0, 32'h0},  // 36 R1 ignored write
        '{1'b0, 1'b1, 9'h0E0, 32'h0, 1'b1, 32'h1}   // 37 R1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_priv = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ext_err_irq = 1'b0;
    logic          err_irq;

    int checks = 0;
    int errors = 0;

    cfg_fault_irq_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_priv    (bus_priv),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_err_irq (ext_err_irq),
        .err_irq     (err_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample read data 1 time unit later,
    // let the rising edge register it, and return idle at the next falling edge.
    task automatic access(input logic we, input logic priv, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wdata, output logic [DW-1:0] rd);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_priv  = priv;
        bus_addr  = addr;
        bus_wdata = wdata;
        #1;
        rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_sel = 1'b0;
        ext_err_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_quiet(input string tag, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            #1;
            check(tag, DW'(err_irq), 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;

        do_reset();
        #1;
        check("R10 err_irq after reset", DW'(err_irq), 0);
        check("R10 read data idle", bus_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].priv, VECS[i].addr, VECS[i].wdata, rd);
            if (VECS[i].chk) begin
                check($sformatf("vector %0d", i), rd, VECS[i].exp);
            end
        end

        // R10: fault registers clear after reset
        do_reset();
        access(1'b0, 1'b1, 9'h0F4, '0, rd);
        check("R10 fault address reset", rd, 0);
        access(1'b0, 1'b1, 9'h0F8, '0, rd);
        check("R10 fault status reset", rd, 0);

        // R6: one pulse, one cycle after the raw bit is set
        access(1'b1, 1'b1, 9'h0E8, 32'h1, rd);
        access(1'b0, 1'b1, 9'h100, '0, rd);
        check("R6 no pulse in first cycle", DW'(err_irq), 0);
        @(negedge clk);
        #1;
        check("R6 pulse", DW'(err_irq), 1);
        @(negedge clk);
        #1;
        check("R6 pulse ends", DW'(err_irq), 0);
        access(1'b0, 1'b1, 9'h100, '0, rd);
        expect_quiet("R6 disarmed while pending", 4);

        // R7: nonzero EOI and non-privileged EOI do not re-arm
        access(1'b1, 1'b1, 9'h0F0, 32'h5, rd);
        expect_quiet("R7 nonzero eoi", 4);
        access(1'b1, 1'b0, 9'h0F0, 32'h0, rd);
        expect_quiet("R7 unprivileged eoi", 4);
        access(1'b0, 1'b1, 9'h0E0, '0, rd);
        check("R2 unprivileged eoi flagged", rd, 3);

        // R7: valid EOI with bit0 still pending gives a new pulse
        access(1'b1, 1'b1, 9'h0F0, 32'h0, rd);
        check("R7 no pulse at eoi", DW'(err_irq), 0);
        @(negedge clk);
        #1;
        check("R7 pulse after eoi", DW'(err_irq), 1);
        @(negedge clk);
        #1;
        check("R7 pulse ends", DW'(err_irq), 0);

        // R7: EOI with nothing pending gives no pulse
        access(1'b1, 1'b1, 9'h0E4, 32'h3, rd);
        access(1'b1, 1'b1, 9'h0F0, 32'h0, rd);
        expect_quiet("R7 eoi nothing pending", 4);

        // R9: external interrupt passes straight through
        @(negedge clk);
        ext_err_irq = 1'b1;
        #1;
        check("R9 ext high", DW'(err_irq), 1);
        ext_err_irq = 1'b0;
        #1;
        check("R9 ext low", DW'(err_irq), 0);

        finish_run();
    end

endmodule